// File: doc/BRIEF.md
# Stage-1 Translation Control Register

This block holds the 64-bit control word for the stage-1 translation regime of the most privileged level. It sits inside a system-register access unit. It compares each incoming access selector (op0, op1, CRn, CRm, op2) with its own fixed encoding. A matching access made at privilege level 3 may read or write the word. A matching access made at any lower level is refused and raises an undefined-instruction flag. An access that does not match leaves the block untouched and produces neither data nor a flag.

Reserved bits are hardwired, so they cannot be changed by a write. The downstream translation logic never sees the raw stored bits. It receives effective values instead, and some of these are gated by other fields. Granule size and physical address width come out already decoded. Reserved or disallowed encodings of those two fields are remapped to a supported size. The raw value written is still what a read returns.

Top module: `xlat_ctl_reg`

## Requirements
- R1: An access is claimed only when {op0,op1,CRn,CRm,op2} equals {2'b11,3'b110,4'b0010,4'b0000,3'b010}. Any other selector, or a cycle with acc_valid low, gives rd_data 0 and undef_flag 0 and leaves the stored word unchanged.
- R2: A claimed access with priv_lvl 0, 1 or 2 drives undef_flag high and rd_data to 0 in the same cycle. If it is a write, the stored word is not changed.
- R3: A claimed write at priv_lvl 3 updates the stored word at the next rising clock edge. A claimed read at priv_lvl 3 returns the stored word combinationally on rd_data.
- R4: Bits 63:32, bit 19 and bits 7:6 always read 0. Bits 31 and 23 always read 1. Every other bit reads back as last written.
- R5: A synchronous active-low reset sets the word to 64'h0000_0000_8080_0000.
- R6: eff_hpd equals bit 24. Each bit of eff_hwu equals the matching stored bit among 28:25 (eff_hwu[0] from bit 25) when bit 24 is 1, and is 0 when bit 24 is 0.
- R7: eff_ha equals bit 21. eff_hd is 1 only when both bit 22 and bit 21 are 1.
- R8: Granule field bits 15:14 set eff_gran_log2 as follows: 2'b00 gives 12, 2'b01 gives 16, 2'b10 gives 14, and the reserved 2'b11 gives 12. Readback keeps the written code.
- R9: Address-size field bits 18:16 with codes 0 to 5 set eff_pa_bits to 32, 36, 40, 42, 44 and 48 respectively.
- R10: Address-size code 6 gives eff_pa_bits 52 only when the granule code is 2'b01; with any other granule code it gives 48. Code 7 always gives 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Selector op0 |
| acc_op1 | input | 3 | Selector op1 |
| acc_crn | input | 4 | Selector CRn |
| acc_crm | input | 4 | Selector CRm |
| acc_op2 | input | 3 | Selector op2 |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, 0 unless a permitted read hits |
| undef_flag | output | 1 | Claimed access refused for privilege |
| eff_hpd | output | 1 | Effective hierarchical-permission disable |
| eff_hwu | output | 4 | Effective hardware-use bits for descriptor bits 62:59 |
| eff_hd | output | 1 | Effective hardware dirty-state management |
| eff_ha | output | 1 | Effective hardware access-flag update |
| eff_gran_log2 | output | 5 | Effective granule size as log2 of bytes |
| eff_pa_bits | output | 6 | Effective physical address width in bits |

## Verification
The address-size and granule decodes depend on each other. A single write can therefore change a read-back field and two effective outputs in the same cycle. The bench writes every pairing of address-size code and granule code, and it compares eff_pa_bits and eff_gran_log2 together against its model on every clock. Refusal and hit decoding can also coincide: a write with the correct selector but a low privilege level has to raise undef_flag and still leave the state unchanged. A write at level 3 whose selector differs in one bit has to do neither. Both cases are followed by a level-3 read-back.

// File: rtl/xlat_ctl_pkg.sv
// Package: shared constants and types for the translation control register.
// Assumes a 64-bit control word; field positions are fixed by the consumers.
package xlat_ctl_pkg;
    localparam int REG_W = 64;

    // Bits that software may change; everything else is hardwired.
    localparam logic [REG_W-1:0] WR_MASK   = 64'h0000_0000_7F77_FF3F;
    // Bits that always read as one.
    localparam logic [REG_W-1:0] FIXED_ONE = 64'h0000_0000_8080_0000;

    // Field positions decoded by downstream logic.
    localparam int POS_HPD    = 24;
    localparam int POS_HWU_LO = 25;
    localparam int HWU_N      = 4;
    localparam int POS_HD     = 22;
    localparam int POS_HA     = 21;
    localparam int POS_PA_LO  = 16;
    localparam int PA_W       = 3;
    localparam int POS_GR_LO  = 14;
    localparam int GR_W       = 2;

    // Output widths.
    localparam int GLOG_W = 5;
    localparam int PAB_W  = 6;

    localparam int SEL_W = 16;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_sel_t;

    typedef enum logic [GR_W-1:0] {
        GR_4K   = 2'b00,
        GR_64K  = 2'b01,
        GR_16K  = 2'b10,
        GR_RSVD = 2'b11
    } gran_code_e;
endpackage

// File: rtl/xlat_ctl_decode.sv
// Module: access decode and privilege gate.
// Compares the selector with MATCH_CODE and splits a claimed access into
// granted (level TOP_LVL) or denied (any lower level). Purely combinational.
module xlat_ctl_decode
    import xlat_ctl_pkg::*;
#(
    parameter logic [SEL_W-1:0] MATCH_CODE = {2'b11, 3'b110, 4'b0010, 4'b0000, 3'b010},
    parameter int               LVL_W      = 2,
    parameter int               TOP_LVL    = 3
) (
    input  sysreg_sel_t      sel,
    input  logic             acc_valid,
    input  logic [LVL_W-1:0] priv_lvl,
    output logic             hit,
    output logic             granted,
    output logic             denied
);
    localparam logic [LVL_W-1:0] TOP_CODE = LVL_W'(TOP_LVL);

    // Selector match and privilege split.
    always_comb begin
        hit     = acc_valid && (sel == MATCH_CODE);
        granted = hit && (priv_lvl == TOP_CODE);
        denied  = hit && (priv_lvl != TOP_CODE);
    end
endmodule

// File: rtl/xlat_ctl_store.sv
// Module: storage for the control word.
// Writable bits take wr_data on wr_en; hardwired bits stay at their fixed
// value. Assumes synchronous active-low reset.
module xlat_ctl_store
    import xlat_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] word_q;

    // Hold the word; reset to the fixed-one pattern, masked update on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= FIXED_ONE;
        else if (wr_en)
            word_q <= (wr_data & WR_MASK) | FIXED_ONE;
    end

    assign q = word_q;
endmodule

// File: rtl/xlat_ctl_effective.sv
// Module: effective-value derivation for the translation logic.
// Applies field gating and remaps reserved or disallowed encodings.
// Combinational; clk/rst_n are used only by the local assertions.
module xlat_ctl_effective
    import xlat_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_raw,
    input  logic [HWU_N-1:0]  hwu_raw,
    input  logic              hd_raw,
    input  logic              ha_raw,
    input  logic [GR_W-1:0]   gran_raw,
    input  logic [PA_W-1:0]   pa_raw,
    output logic              eff_hpd,
    output logic [HWU_N-1:0]  eff_hwu,
    output logic              eff_hd,
    output logic              eff_ha,
    output logic [GLOG_W-1:0] eff_gran_log2,
    output logic [PAB_W-1:0]  eff_pa_bits
);
    gran_code_e gcode;
    assign gcode   = gran_code_e'(gran_raw);
    assign eff_hpd = hpd_raw;

    // One gate per hardware-use bit, all enabled by the permission disable.
    for (genvar i = 0; i < HWU_N; i++) begin : g_hwu
        assign eff_hwu[i] = hwu_raw[i] & hpd_raw;
    end

    // Dirty management needs access-flag management.
    always_comb begin
        eff_ha = ha_raw;
        eff_hd = hd_raw & ha_raw;
    end

    // Granule decode; the reserved code falls back to the smallest size.
    always_comb begin
        unique case (gcode)
            GR_64K:  eff_gran_log2 = GLOG_W'(16);
            GR_16K:  eff_gran_log2 = GLOG_W'(14);
            default: eff_gran_log2 = GLOG_W'(12);
        endcase
    end

    // Physical width decode; widest code only with the large granule.
    always_comb begin
        case (pa_raw)
            3'd0:    eff_pa_bits = PAB_W'(32);
            3'd1:    eff_pa_bits = PAB_W'(36);
            3'd2:    eff_pa_bits = PAB_W'(40);
            3'd3:    eff_pa_bits = PAB_W'(42);
            3'd4:    eff_pa_bits = PAB_W'(44);
            3'd6:    eff_pa_bits = (gcode == GR_64K) ? PAB_W'(52) : PAB_W'(48);
            default: eff_pa_bits = PAB_W'(48);
        endcase
    end

    AST_HWU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !eff_hpd |-> (eff_hwu == '0));                                   // R6
    AST_HD_NEEDS_HA: assert property (@(posedge clk) disable iff (!rst_n)
        eff_hd |-> eff_ha);                                              // R7
    AST_GRAN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_gran_log2 == 5'd12) || (eff_gran_log2 == 5'd14) || (eff_gran_log2 == 5'd16)); // R8
    AST_PA_WIDE_NEEDS_BIG_GRAN: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_pa_bits == 6'd52) |-> (eff_gran_log2 == 5'd16));            // R10
endmodule

// File: rtl/xlat_ctl_reg.sv
// Module: top of the stage-1 translation control register.
// Decodes accesses, gates them by privilege, stores the word and drives
// effective values. Assumes one access per cycle, synchronous active-low reset.
module xlat_ctl_reg
    import xlat_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_op0,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [1:0]        priv_lvl,
    input  logic [63:0]       wr_data,
    output logic [63:0]       rd_data,
    output logic              undef_flag,
    output logic              eff_hpd,
    output logic [3:0]        eff_hwu,
    output logic              eff_hd,
    output logic              eff_ha,
    output logic [4:0]        eff_gran_log2,
    output logic [5:0]        eff_pa_bits
);
    sysreg_sel_t      sel;
    logic             hit, granted, denied;
    logic [REG_W-1:0] cfg_q;

    assign sel = '{op0: acc_op0, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

    xlat_ctl_decode #(
        .MATCH_CODE ({2'b11, 3'b110, 4'b0010, 4'b0000, 3'b010}),
        .LVL_W      (2),
        .TOP_LVL    (3)
    ) u_dec (
        .sel       (sel),
        .acc_valid (acc_valid),
        .priv_lvl  (priv_lvl),
        .hit       (hit),
        .granted   (granted),
        .denied    (denied)
    );

    xlat_ctl_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (granted && acc_write),
        .wr_data (wr_data),
        .q       (cfg_q)
    );

    xlat_ctl_effective u_eff (
        .clk           (clk),
        .rst_n         (rst_n),
        .hpd_raw       (cfg_q[POS_HPD]),
        .hwu_raw       (cfg_q[POS_HWU_LO +: HWU_N]),
        .hd_raw        (cfg_q[POS_HD]),
        .ha_raw        (cfg_q[POS_HA]),
        .gran_raw      (cfg_q[POS_GR_LO +: GR_W]),
        .pa_raw        (cfg_q[POS_PA_LO +: PA_W]),
        .eff_hpd       (eff_hpd),
        .eff_hwu       (eff_hwu),
        .eff_hd        (eff_hd),
        .eff_ha        (eff_ha),
        .eff_gran_log2 (eff_gran_log2),
        .eff_pa_bits   (eff_pa_bits)
    );

    // Read return and refusal flag.
    always_comb begin
        rd_data    = (granted && !acc_write) ? cfg_q : '0;
        undef_flag = denied;
    end

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!undef_flag && rd_data == '0));                        // R1
    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cfg_q));                                        // R1
    AST_DENY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |=> $stable(cfg_q));                                  // R2
    AST_DENY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (rd_data == '0));                                 // R2
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[31] && cfg_q[23] && !cfg_q[19] && (cfg_q[7:6] == 2'b00)
        && (cfg_q[63:32] == 32'h0));                                     // R4
endmodule

// File: tb/xlat_ctl_reg_test.sv
`timescale 1ns/1ps
module xlat_ctl_reg_test;
    localparam logic [15:0] SEL_OK = {2'b11, 3'b110, 4'b0010, 4'b0000, 3'b010};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, acc_valid, acc_write;
    logic [15:0] code;
    logic [1:0]  priv_lvl;
    logic [63:0] wr_data, rd_data;
    logic        undef_flag, eff_hpd, eff_hd, eff_ha;
    logic [3:0]  eff_hwu;
    logic [4:0]  eff_gran_log2;
    logic [5:0]  eff_pa_bits;

    xlat_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op0(code[15:14]), .acc_op1(code[13:11]), .acc_crn(code[10:7]),
        .acc_crm(code[6:3]), .acc_op2(code[2:0]), .priv_lvl(priv_lvl),
        .wr_data(wr_data), .rd_data(rd_data), .undef_flag(undef_flag),
        .eff_hpd(eff_hpd), .eff_hwu(eff_hwu), .eff_hd(eff_hd), .eff_ha(eff_ha),
        .eff_gran_log2(eff_gran_log2), .eff_pa_bits(eff_pa_bits)
    );

    int          n_run = 0, n_fail = 0;
    logic [63:0] m_reg;
    bit          model_on = 0;
    string       cur_tag = "R5";

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: stored word after a permitted write.
    function automatic logic [63:0] after_write(logic [63:0] d);
        logic [63:0] v = d;
        v[63:32] = '0; v[19] = 1'b0; v[7:6] = 2'b00;
        v[31] = 1'b1;  v[23] = 1'b1;
        return v;
    endfunction

    function automatic int gran_of(logic [1:0] g);
        if (g == 2'b01) return 16;
        if (g == 2'b10) return 14;
        return 12;
    endfunction

    function automatic int pa_of(logic [2:0] p, logic [1:0] g);
        int tbl[6] = '{32, 36, 40, 42, 44, 48};
        if (p < 6) return tbl[p];
        if (p == 6 && g == 2'b01) return 52;
        return 48;
    endfunction

    function automatic logic [63:0] mk(bit hpd, logic [3:0] hwu, bit hd, bit ha,
                                       logic [2:0] pa, logic [1:0] g);
        logic [63:0] v = '0;
        v[24] = hpd; v[28:25] = hwu; v[22] = hd; v[21] = ha;
        v[18:16] = pa; v[15:14] = g;
        return v;
    endfunction

    // Compare effective outputs with the model on every clock (R6..R10).
    always @(negedge clk) begin
        if (model_on) begin
            check({cur_tag, " R6 hpd"}, 64'(eff_hpd), 64'(m_reg[24]));
            check({cur_tag, " R6 hwu"}, 64'(eff_hwu), m_reg[24] ? 64'(m_reg[28:25]) : 64'd0);
            check({cur_tag, " R7 ha"},  64'(eff_ha), 64'(m_reg[21]));
            check({cur_tag, " R7 hd"},  64'(eff_hd), 64'(m_reg[22] && m_reg[21]));
            check({cur_tag, " R8 gran"}, 64'(eff_gran_log2), 64'(gran_of(m_reg[15:14])));
            check({cur_tag, " R9/R10 pa"}, 64'(eff_pa_bits),
                  64'(pa_of(m_reg[18:16], m_reg[15:14])));
        end
    end

    task automatic access(string tag, bit vld, bit wr, logic [1:0] lvl,
                          logic [15:0] c, logic [63:0] d);
        bit hitx;
        @(negedge clk);
        cur_tag = tag;
        acc_valid = vld; acc_write = wr; priv_lvl = lvl; code = c; wr_data = d;
        #1;
        hitx = vld && (c == SEL_OK);
        check({tag, " undef"}, 64'(undef_flag), 64'(hitx && lvl != 2'd3));
        check({tag, " rd"}, rd_data, (hitx && lvl == 2'd3 && !wr) ? m_reg : 64'd0);
        @(posedge clk);
        if (hitx && wr && lvl == 2'd3) m_reg = after_write(d);
        #1 acc_valid = 1'b0;
    endtask

    task automatic rd3(string tag);
        access(tag, 1'b1, 1'b0, 2'd3, SEL_OK, 64'd0);
    endtask

    task automatic wr3(string tag, logic [63:0] d);
        access(tag, 1'b1, 1'b1, 2'd3, SEL_OK, d);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; priv_lvl = 2'd0;
        code = '0; wr_data = '0;
        m_reg = 64'h0000_0000_8080_0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        model_on = 1;
        // R5: reset value
        rd3("R5");
        // R3/R4: all ones and all zeros
        wr3("R4 ones", '1);
        rd3("R4 ones rb");
        check("R4 literal", m_reg, 64'h0000_0000_FFF7_FF3F);
        wr3("R4 zeros", 64'd0);
        rd3("R4 zeros rb");
        wr3("R3 pattern", 64'hA5A5_5A5A_3C3C_C3C3);
        rd3("R3 pattern rb");
        // R6: hwu gating
        wr3("R6 hpd0", mk(0, 4'hF, 0, 0, 3'd0, 2'b00));
        wr3("R6 hpd1", mk(1, 4'hA, 0, 0, 3'd0, 2'b00));
        wr3("R6 hpd1b", mk(1, 4'h5, 0, 0, 3'd0, 2'b00));
        // R7: dirty needs access flag
        wr3("R7 hd only", mk(0, 0, 1, 0, 3'd0, 2'b00));
        wr3("R7 both", mk(0, 0, 1, 1, 3'd0, 2'b00));
        wr3("R7 ha only", mk(0, 0, 0, 1, 3'd0, 2'b00));
        // R8/R9/R10: every size pairing, readback keeps the raw codes
        for (int g = 0; g < 4; g++) begin
            for (int p = 0; p < 8; p++) begin
                wr3("R9/R10 sweep", mk(0, 0, 0, 0, 3'(p), 2'(g)));
                rd3("R8 raw rb");
            end
        end
        // R2: low privilege refused
        wr3("R2 setup", 64'h0000_0000_1234_5678);
        for (int l = 0; l < 3; l++) begin
            access("R2 wr", 1'b1, 1'b1, 2'(l), SEL_OK, 64'hFFFF_FFFF_FFFF_FFFF);
            access("R2 rd", 1'b1, 1'b0, 2'(l), SEL_OK, 64'd0);
        end
        rd3("R2 unchanged");
        // R1: one-bit selector mismatch, and valid low
        for (int b = 0; b < 16; b++) begin
            access("R1 miss wr", 1'b1, 1'b1, 2'd3, SEL_OK ^ (16'd1 << b), 64'h0000_0000_0100_4000);
            access("R1 miss rd", 1'b1, 1'b0, 2'd3, SEL_OK ^ (16'd1 << b), 64'd0);
        end
        access("R1 idle", 1'b0, 1'b1, 2'd3, SEL_OK, 64'd0);
        rd3("R1 unchanged");
        // R5: reset again after content
        wr3("R5 pre", '1);
        @(negedge clk);
        model_on = 0;
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        m_reg = 64'h0000_0000_8080_0000;
        model_on = 1;
        rd3("R5 again");
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule